// File: doc/BRIEF.md
# Waveform Line Sequencer

The sequencer walks a list of waveform lines stored in a 16-bit-wide channel memory and paces them in time. Each line starts with a header word, then a duration word, then zero to fourteen coefficient words. The header packs the line length, the line type, an update-rate shift and the control flags. The block streams the coefficient words to a downstream interpolator through a load strobe, tagged with their index. It then holds the line for its duration, counted in update ticks. An update tick is the sample clock divided by two raised to the line's shift.

The bottom words of memory form a frame table of start addresses. After reset, and whenever a line carries the jump flag, the sequencer reads the table entry picked by the frame-select input and continues from that address. Otherwise it moves on to the word that follows the line. A line can stall at its end until the trigger input is asserted. It can also ask the interpolator to zero its accumulators before the new coefficients arrive, mute the output for the whole line, drive an auxiliary output, and emit a marker pulse when its hold starts.

Top module: `wave_line_seq`

## Requirements
- R1: While rst_ni is low, coef_valid_o, tick_o, clear_o, mark_o, line_active_o and waiting_o are 0 and mem_addr_o is 0. After release, the first line fetched is the one at the address stored in frame-table word frame_sel_i.
- R2: The header field bits [3:0] gives the line length L: the duration word plus the data words. A line with L >= 1 produces exactly L-1 strobes on coef_valid_o. coef_data_o carries the data words in memory order, and coef_idx_o counts 0 to L-2. L = 0 behaves as L = 1.
- R3: The duration word D (unsigned, directly after the header) yields max(D,1) pulses on tick_o. Consecutive pulses within a line are 2^S clock cycles apart, where S is header bits [12:9].
- R4: line_type_o shows header bits [5:4] (0 = polynomial, 1 = oscillator) and aux_o shows header bit 8. Both hold for every tick of that line.
- R5: silence_o equals header bit 7 of the current line on every tick of that line.
- R6: When header bit 14 (clear) is set, clear_o pulses exactly once for that line, in a cycle before its first coefficient strobe. A line without the bit gives no pulse.
- R7: When header bit 15 (wait) is set, waiting_o rises after the last tick. No fetch, strobe or tick follows until trigger_i is seen high, and then sequencing resumes.
- R8: When header bit 13 (jump) is set, the next line is taken from frame-table word frame_sel_i, read when the line ends, rather than from the following address.
- R9: Without jump, the next header is read from the address directly after the line's last word (header address + L + 1).
- R10: When header bit 6 is set, mark_o pulses once for that line, as its hold starts. A line without the bit gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | AW | Channel memory read address; data returns one cycle later |
| mem_data_i | input | 16 | Channel memory read data |
| frame_sel_i | input | FW | Frame-table entry used on start and on jump |
| trigger_i | input | 1 | Releases a line stalled on its wait flag |
| coef_valid_o | output | 1 | Coefficient load strobe |
| coef_idx_o | output | 4 | Index of the coefficient word within its line |
| coef_data_o | output | 16 | Coefficient word |
| clear_o | output | 1 | Zero the interpolator accumulators |
| silence_o | output | 1 | Force the output to zero for the current line |
| aux_o | output | 1 | Auxiliary output of the current line |
| line_type_o | output | 2 | Line type of the current line |
| mark_o | output | 1 | Pulse at hold start of a line with the marker flag |
| tick_o | output | 1 | Update tick of the held line |
| line_active_o | output | 1 | A line is being held |
| waiting_o | output | 1 | Stalled, waiting for trigger_i |

## Verification
The hardest case to reach from the ports is a wait stall on a line that also jumps. The frame-select value that matters is the one present when the stall is released, and the bench has to show that nothing moves during the stall. The stimulus parks the sequencer on such a line and idles for many cycles, checking that ticks and strobes stay frozen. It then changes frame_sel_i and pulses trigger_i. A decoy line sits at the sequential address, so a missing jump shows up as a wrong coefficient value. Zero duration combined with a large shift, and a clear flag on a line with data words, are placed in their own programs.

// File: rtl/wls_pkg.sv
package wls_pkg;
  localparam int WORD_W  = 16;
  localparam int LEN_W   = 4;
  localparam int SHIFT_W = 4;

  typedef enum logic [1:0] {LT_POLY = 2'd0, LT_OSC = 2'd1, LT_RSV2 = 2'd2, LT_RSV3 = 2'd3} line_type_e;

  // packed MSB first so a 16-bit header word casts directly
  typedef struct packed {
    logic               wait_trig;  // 15
    logic               clear;      // 14
    logic               jump;       // 13
    logic [SHIFT_W-1:0] shift;      // 12:9
    logic               aux;        // 8
    logic               silence;    // 7
    logic               mark;       // 6
    line_type_e         ltype;      // 5:4
    logic [LEN_W-1:0]   len;        // 3:0
  } hdr_t;

  typedef enum logic [3:0] {
    S_JMP, S_TAB, S_PTR, S_ADDR, S_HDR, S_DUR, S_DATA, S_HOLD, S_WAIT
  } seq_state_e;
endpackage

// File: rtl/wls_hdr_dec.sv
module wls_hdr_dec
  import wls_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output hdr_t              hdr_o,
  output logic [LEN_W-1:0]  ndata_o
);
  always_comb begin
    hdr_o   = hdr_t'(word_i);
    ndata_o = (hdr_o.len == '0) ? '0 : hdr_o.len - LEN_W'(1);
  end
endmodule

// File: rtl/wls_tick_gen.sv
module wls_tick_gen #(
  parameter int SHIFT_W = 4,
  parameter int DUR_W   = 16,
  localparam int PW     = (1 << SHIFT_W) - 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [SHIFT_W-1:0] shift_i,
  input  logic [DUR_W-1:0]   dur_i,
  output logic               tick_o,
  output logic               done_o,
  output logic               active_o
);
  logic [PW-1:0]    presc_q, limit_q;
  logic [DUR_W-1:0] rem_q;
  logic             active_q;

  assign tick_o   = active_q && (presc_q == limit_q);
  assign done_o   = tick_o && (rem_q == DUR_W'(1));
  assign active_o = active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      presc_q  <= '0;
      limit_q  <= '0;
      rem_q    <= '0;
      active_q <= 1'b0;
    end else if (start_i) begin
      active_q <= 1'b1;
      presc_q  <= '0;
      limit_q  <= ~({PW{1'b1}} << shift_i);
      rem_q    <= (dur_i == '0) ? DUR_W'(1) : dur_i;  // zero counts as one tick
    end else if (active_q) begin
      if (tick_o) begin
        presc_q <= '0;
        rem_q   <= rem_q - DUR_W'(1);
        if (rem_q == DUR_W'(1)) active_q <= 1'b0;
      end else begin
        presc_q <= presc_q + PW'(1);
      end
    end
  end

  p_rem_live_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q |-> rem_q != '0);
  p_start_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !active_q);
endmodule

// File: rtl/wave_line_seq.sv
module wave_line_seq
  import wls_pkg::*;
#(
  parameter int AW         = 12,
  parameter int NUM_FRAMES = 8,
  localparam int FW        = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [AW-1:0]     mem_addr_o,
  input  logic [WORD_W-1:0] mem_data_i,
  input  logic [FW-1:0]     frame_sel_i,
  input  logic              trigger_i,
  output logic              coef_valid_o,
  output logic [LEN_W-1:0]  coef_idx_o,
  output logic [WORD_W-1:0] coef_data_o,
  output logic              clear_o,
  output logic              silence_o,
  output logic              aux_o,
  output logic [1:0]        line_type_o,
  output logic              mark_o,
  output logic              tick_o,
  output logic              line_active_o,
  output logic              waiting_o
);
  seq_state_e        state_q;
  logic [AW-1:0]     addr_q, next_q;
  hdr_t              hdr_q, hdr_w;
  logic [LEN_W-1:0]  ndata_q, ndata_w, widx_q;
  logic [WORD_W-1:0] dur_q, hold_dur;
  logic              hold_start, tk_done, advance;

  wls_hdr_dec u_dec (
    .word_i (mem_data_i),
    .hdr_o  (hdr_w),
    .ndata_o(ndata_w)
  );

  assign hold_start = (state_q == S_DUR  && ndata_q == '0) ||
                      (state_q == S_DATA && widx_q == ndata_q - LEN_W'(1));
  assign hold_dur   = (state_q == S_DUR) ? mem_data_i : dur_q;

  wls_tick_gen #(.SHIFT_W(SHIFT_W), .DUR_W(WORD_W)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (hold_start),
    .shift_i (hdr_q.shift),
    .dur_i   (hold_dur),
    .tick_o  (tick_o),
    .done_o  (tk_done),
    .active_o(line_active_o)
  );

  assign advance = (state_q == S_HOLD && tk_done && !hdr_q.wait_trig) ||
                   (state_q == S_WAIT && trigger_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_JMP;
      addr_q  <= '0;
      next_q  <= '0;
      hdr_q   <= '0;
      ndata_q <= '0;
      widx_q  <= '0;
      dur_q   <= '0;
    end else begin
      unique case (state_q)
        S_JMP: begin
          addr_q  <= AW'(frame_sel_i);
          state_q <= S_TAB;
        end
        S_TAB:  state_q <= S_PTR;
        S_PTR: begin
          addr_q  <= mem_data_i[AW-1:0];
          state_q <= S_ADDR;
        end
        S_ADDR: begin
          addr_q  <= addr_q + AW'(1);
          state_q <= S_HDR;
        end
        S_HDR: begin
          hdr_q   <= hdr_w;
          ndata_q <= ndata_w;
          next_q  <= addr_q + AW'(ndata_w) + AW'(1);
          addr_q  <= addr_q + AW'(1);
          state_q <= S_DUR;
        end
        S_DUR: begin
          dur_q   <= mem_data_i;
          widx_q  <= '0;
          addr_q  <= addr_q + AW'(1);
          state_q <= (ndata_q == '0) ? S_HOLD : S_DATA;
        end
        S_DATA: begin
          addr_q <= addr_q + AW'(1);
          if (hold_start) state_q <= S_HOLD;
          else            widx_q  <= widx_q + LEN_W'(1);
        end
        S_HOLD: if (tk_done && hdr_q.wait_trig) state_q <= S_WAIT;
        S_WAIT: ;
        default: state_q <= S_JMP;
      endcase
      if (advance) begin
        if (hdr_q.jump) state_q <= S_JMP;
        else begin
          addr_q  <= next_q;
          state_q <= S_ADDR;
        end
      end
    end
  end

  assign mem_addr_o   = addr_q;
  assign coef_valid_o = (state_q == S_DATA);
  assign coef_idx_o   = widx_q;
  assign coef_data_o  = mem_data_i;
  assign clear_o      = (state_q == S_DUR) && hdr_q.clear;
  assign mark_o       = hold_start && hdr_q.mark;
  assign silence_o    = hdr_q.silence;
  assign aux_o        = hdr_q.aux;
  assign line_type_o  = hdr_q.ltype;
  assign waiting_o    = (state_q == S_WAIT);

  p_tick_in_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> state_q == S_HOLD);
  p_coef_idx_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coef_valid_o |-> coef_idx_o < hdr_q.len);
  p_wait_holds_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (waiting_o && !trigger_i) |=> (waiting_o && $stable(mem_addr_o) && !tick_o));
  p_clear_no_coef_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |-> !coef_valid_o);
  p_clear_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_o |=> !clear_o);
  p_silence_steady_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_HOLD && $past(state_q == S_HOLD)) |-> $stable(silence_o));
endmodule

// File: tb/sim_wave_line_seq.sv
`timescale 1ns/1ps
module sim_wave_line_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] mem_addr_o;
  logic [15:0] mem_data_i;
  logic [2:0]  frame_sel_i = '0;
  logic        trigger_i = 1'b0;
  logic        coef_valid_o, clear_o, silence_o, aux_o, mark_o, tick_o, line_active_o, waiting_o;
  logic [3:0]  coef_idx_o;
  logic [15:0] coef_data_o;
  logic [1:0]  line_type_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  wave_line_seq u0 (.*);

  logic [15:0] mem [256];
  always_ff @(posedge clk_i) mem_data_i <= mem[mem_addr_o[7:0]];

  int n_checks = 0, n_errors = 0, cyc = 0;
  int n_coef, n_tick, n_clr, n_mark, clr_cyc;
  int c_data[16], c_idx[16], c_cyc[16];
  int t_cyc[16], t_sil[16], t_aux[16], t_typ[16];

  always @(posedge clk_i) cyc <= cyc + 1;

  always @(negedge clk_i) if (rst_ni) begin
    if (coef_valid_o) begin
      if (n_coef < 16) begin
        c_data[n_coef] = coef_data_o; c_idx[n_coef] = coef_idx_o; c_cyc[n_coef] = cyc;
      end
      n_coef++;
    end
    if (tick_o) begin
      if (n_tick < 16) begin
        t_cyc[n_tick] = cyc; t_sil[n_tick] = silence_o;
        t_aux[n_tick] = aux_o; t_typ[n_tick] = line_type_o;
      end
      n_tick++;
    end
    if (clear_o) begin clr_cyc = cyc; n_clr++; end
    if (mark_o) n_mark++;
  end

  function automatic logic [15:0] mk_hdr(int len, int typ, int mrk, int sil, int aux,
                                         int sh, int jmp, int clr, int wt);
    return 16'(len | (typ << 4) | (mrk << 6) | (sil << 7) | (aux << 8) |
               (sh << 9) | (jmp << 13) | (clr << 14) | (wt << 15));
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mem_clear();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
  endtask

  task automatic apply_reset(input int frame);
    rst_ni = 1'b0; trigger_i = 1'b0; frame_sel_i = 3'(frame);
    repeat (3) @(negedge clk_i);
    chk(!coef_valid_o && !tick_o && !clear_o && !mark_o, "R1 reset strobes", 1, 0);
    chk(!line_active_o && !waiting_o, "R1 reset status", {line_active_o, waiting_o}, 0);
    chk(mem_addr_o == 0, "R1 reset addr", mem_addr_o, 0);
    n_coef = 0; n_tick = 0; n_clr = 0; n_mark = 0; clr_cyc = 0;
    rst_ni = 1'b1;
  endtask

  task automatic wait_stall(input string req);
    int k = 0;
    while (!waiting_o && k < 3000) begin @(negedge clk_i); k++; end
    chk(waiting_o, req, 0, 1);
  endtask

  // R1 R2 R4 R9 R10: start via table, data streaming, field outputs, sequential next
  task automatic t_basic();
    mem_clear();
    mem[2] = 16'd16;
    mem[16] = mk_hdr(4, 1, 1, 0, 1, 0, 0, 0, 0); mem[17] = 16'd3;
    mem[18] = 16'h1111; mem[19] = 16'h2222; mem[20] = 16'h3333;
    mem[21] = mk_hdr(1, 0, 0, 0, 0, 1, 0, 0, 1); mem[22] = 16'd2;
    apply_reset(2);
    wait_stall("R1 start from frame 2");
    chk(n_coef == 3, "R2 coef count", n_coef, 3);
    for (int i = 0; i < 3; i++) begin
      chk(c_data[i] == 16'h1111 * (i + 1), "R2 coef data", c_data[i], 16'h1111 * (i + 1));
      chk(c_idx[i] == i, "R2 coef idx", c_idx[i], i);
    end
    chk(n_tick == 5, "R9 ticks over both lines", n_tick, 5);
    chk(t_typ[0] == 1 && t_aux[2] == 1, "R4 type/aux line 1", {t_typ[0], t_aux[2]}, 3);
    chk(t_typ[3] == 0 && t_aux[4] == 0, "R4 type/aux line 2", {t_typ[3], t_aux[4]}, 0);
    chk(t_cyc[4] - t_cyc[3] == 2, "R9 sequential line shift 1", t_cyc[4] - t_cyc[3], 2);
    chk(n_mark == 1, "R10 marker pulses", n_mark, 1);
  endtask

  // R3: zero duration and tick spacing
  task automatic t_ticks();
    mem_clear();
    mem[0] = 16'd30;
    mem[30] = mk_hdr(1, 0, 0, 0, 0, 3, 0, 0, 0); mem[31] = 16'd0;
    mem[32] = mk_hdr(0, 0, 0, 0, 0, 2, 0, 0, 1); mem[33] = 16'd3;
    apply_reset(0);
    wait_stall("R3 stall reached");
    chk(n_tick == 4, "R3 zero duration gives one tick", n_tick, 4);
    chk(t_cyc[2] - t_cyc[1] == 4, "R3 spacing shift 2", t_cyc[2] - t_cyc[1], 4);
    chk(t_cyc[3] - t_cyc[2] == 4, "R3 spacing shift 2", t_cyc[3] - t_cyc[2], 4);
    chk(n_coef == 0, "R2 length zero no data", n_coef, 0);
  endtask

  // R5 R6: clear pulse and silence
  task automatic t_flags();
    mem_clear();
    mem[0] = 16'd50;
    mem[50] = mk_hdr(3, 0, 0, 1, 0, 0, 0, 1, 0); mem[51] = 16'd2;
    mem[52] = 16'h00A1; mem[53] = 16'h00A2;
    mem[54] = mk_hdr(2, 0, 0, 0, 0, 0, 0, 0, 1); mem[55] = 16'd1; mem[56] = 16'h00C3;
    apply_reset(0);
    wait_stall("R6 stall reached");
    chk(n_clr == 1, "R6 clear count", n_clr, 1);
    chk(clr_cyc < c_cyc[0], "R6 clear before first coef", clr_cyc, c_cyc[0]);
    chk(n_coef == 3 && c_data[2] == 16'h00C3, "R2 coef across lines", c_data[2], 16'h00C3);
    chk(t_sil[0] == 1 && t_sil[1] == 1, "R5 silence on line", t_sil[0] + t_sil[1], 2);
    chk(t_sil[2] == 0, "R5 silence off next line", t_sil[2], 0);
    chk(n_mark == 0, "R10 no marker without flag", n_mark, 0);
  endtask

  // R7 R8: stall, release, jump via frame select
  task automatic t_wait_jump();
    mem_clear();
    mem[0] = 16'd10; mem[5] = 16'd40;
    mem[10] = mk_hdr(1, 0, 0, 0, 0, 0, 1, 0, 1); mem[11] = 16'd1;
    mem[12] = mk_hdr(2, 0, 0, 0, 0, 0, 0, 0, 1); mem[13] = 16'd1; mem[14] = 16'hDEAD;
    mem[40] = mk_hdr(2, 1, 0, 0, 0, 0, 0, 0, 1); mem[41] = 16'd1; mem[42] = 16'hBEEF;
    apply_reset(0);
    wait_stall("R7 first stall");
    chk(n_tick == 1 && n_coef == 0, "R7 state at stall", n_tick * 16 + n_coef, 16);
    repeat (20) @(negedge clk_i);
    chk(waiting_o, "R7 still stalled", waiting_o, 1);
    chk(n_tick == 1 && n_coef == 0, "R7 frozen while stalled", n_tick * 16 + n_coef, 16);
    frame_sel_i = 3'd5; trigger_i = 1'b1;
    @(negedge clk_i); trigger_i = 1'b0;
    chk(!waiting_o, "R7 released", waiting_o, 0);
    wait_stall("R8 second stall");
    chk(n_coef == 1 && c_data[0] == 16'hBEEF, "R8 jump target data", c_data[0], 16'hBEEF);
    chk(n_tick == 2 && t_typ[1] == 1, "R8 jump target type", t_typ[1], 1);
  endtask

  initial begin
    fork
      begin
        t_basic();
        t_ticks();
        t_flags();
        t_wait_jump();
      end
      begin
        repeat (100000) @(posedge clk_i);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule